// File: doc/BRIEF.md
# Two-Wire Strobed Byte Port

This block moves bytes across one 8-bit parallel pin group using a pair of handshake wires. One wire is an active-low data strobe and the other is an active-high acknowledge/ready line. A single mode input picks the direction of the whole port.

In output mode the port drives the data pins and the strobe, and listens to the ready line. The core side hands over a byte through a write strobe, and a busy flag stays high until the far end has finished the exchange. In input mode the roles swap. The port listens to the strobe and drives ready. Each byte received is offered to the core on a read bus together with a one-cycle valid pulse.

All minimum intervals are counted in system clock cycles and set by parameters: the data setup time, the strobe hold time and the gap between transfers. Both incoming handshake lines pass through a two-stage synchronizer before any state machine sees them.

Top module: `strobe_port`

## Requirements
- R1: While `rst` is high and on the first cycle after it: `busy`=0, `rd_valid`=0, `rd_data`=0, `dav_n_out`=1 and `rdy_out`=1.
- R2: With `mode_out`=1 the port drives data and strobe (`pin_data_oe`=1, `dav_oe`=1, `rdy_oe`=0). With `mode_out`=0 it drives only ready (`pin_data_oe`=0, `dav_oe`=0, `rdy_oe`=1).
- R3: In output mode a write accepted while idle places the byte on `pin_data_out` on the next cycle. The byte then holds there for at least `SETUP_CYC` cycles before `dav_n_out` falls. When ready is already high, the fall comes exactly `SETUP_CYC` cycles after the byte appears.
- R4: In output mode `dav_n_out` stays low until the synchronized ready is seen low. It then rises exactly `DAV_MIN_CYC` cycles later, which is `DAV_MIN_CYC`+3 cycles after `rdy_in` falls.
- R5: In output mode `busy` clears exactly `GAP_CYC`+3 cycles after `rdy_in` rises again. No strobe fall comes earlier than `GAP_CYC`+`SETUP_CYC` cycles after a ready rise.
- R6: In output mode a write while `busy`=1 is ignored and `pin_data_out` keeps its byte. `busy` stays high through the whole exchange.
- R7: In input mode the byte on `pin_data_in` is latched on the first synchronized strobe-low sample, 3 cycles after `dav_n_in` falls. In that same cycle `rd_valid` pulses for exactly one cycle and `rdy_out` falls.
- R8: In input mode `rdy_out` stays low while `dav_n_in` is low. It rises exactly `GAP_CYC`+3 cycles after `dav_n_in` returns high.
- R9: Stimulus on the other direction's lines has no effect. Writes in input mode leave `busy`=0 and `dav_n_out`=1. A low `dav_n_in` in output mode gives no `rd_valid` and leaves `rdy_out`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_out | input | 1 | 1 = port sends bytes, 0 = port receives bytes |
| wr_en | input | 1 | Core write strobe (output mode) |
| wr_data | input | 8 | Byte to send |
| busy | output | 1 | An exchange is in progress; writes are ignored |
| rd_data | output | 8 | Last byte received |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds a new byte |
| pin_data_in | input | 8 | Data pins as seen from outside |
| pin_data_out | output | 8 | Data pins drive value |
| pin_data_oe | output | 1 | Data pins output enable |
| dav_n_in | input | 1 | Strobe line from the far end (active low) |
| dav_n_out | output | 1 | Strobe drive value (active low) |
| dav_oe | output | 1 | Strobe output enable |
| rdy_in | input | 1 | Ready line from the far end |
| rdy_out | output | 1 | Ready drive value |
| rdy_oe | output | 1 | Ready output enable |

## Verification
Output mode is exercised with a far-end receiver model that answers quickly (one cycle) and slowly (six cycles). Comparing the two shows that the strobe waits for ready rather than for a timer, while the release and gap delays stay fixed. Back-to-back writes of the byte values 0x00, 0xFF, 0xA5 and 0x5A test the setup window and the data path. A write issued during an exchange checks that a busy port ignores it. Input mode is exercised with strobe widths from one to five cycles, so that ready is seen to follow the strobe and not a fixed count. The data pins are changed after ready falls, which shows that the latch point is the first synchronized strobe sample.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

    localparam int SYNC_STAGES = 2;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_SETUP,
        TX_STROBE,
        TX_HOLD,
        TX_RELEASE,
        TX_GAP
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_READY,
        RX_ACK,
        RX_GAP
    } rx_state_e;

    typedef struct packed {
        logic dav_n;
        logic rdy;
    } hs_lines_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int cbits(input int m);
        int r;
        r = 1;
        while ((1 << r) <= m) r++;
        return r;
    endfunction

endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/hsp_tx.sv
module hsp_tx #(
    parameter int DW = 8,
    parameter int SETUP_CYC = 2,
    parameter int DAV_MIN_CYC = 3,
    parameter int GAP_CYC = 2,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rdy_s,
    output logic          busy,
    output logic [DW-1:0] data_out,
    output logic          dav_n
);
    hsp_pkg::tx_state_e st;
    logic [CW-1:0]      cnt;
    logic [DW-1:0]      dq;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st  <= hsp_pkg::TX_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                hsp_pkg::TX_IDLE: if (wr_en) begin
                    st  <= hsp_pkg::TX_SETUP;
                    cnt <= CW'(SETUP_CYC - 1);
                end
                hsp_pkg::TX_SETUP: begin
                    if (cnt != '0) cnt <= cnt - CW'(1);
                    else if (rdy_s) st <= hsp_pkg::TX_STROBE;
                end
                hsp_pkg::TX_STROBE: if (!rdy_s) begin
                    st  <= hsp_pkg::TX_HOLD;
                    cnt <= CW'(DAV_MIN_CYC - 1);
                end
                hsp_pkg::TX_HOLD: begin
                    if (cnt != '0) cnt <= cnt - CW'(1);
                    else st <= hsp_pkg::TX_RELEASE;
                end
                hsp_pkg::TX_RELEASE: if (rdy_s) begin
                    st  <= hsp_pkg::TX_GAP;
                    cnt <= CW'(GAP_CYC - 1);
                end
                hsp_pkg::TX_GAP: begin
                    if (cnt != '0) cnt <= cnt - CW'(1);
                    else st <= hsp_pkg::TX_IDLE;
                end
                default: st <= hsp_pkg::TX_IDLE;
            endcase
        end
    end

    // Byte register loads only from idle, so a busy port keeps its byte.
    always_ff @(posedge clk) begin
        if (rst) dq <= '0;
        else if (en && st == hsp_pkg::TX_IDLE && wr_en) dq <= wr_data;
    end

    assign busy     = (st != hsp_pkg::TX_IDLE);
    assign dav_n    = !(st == hsp_pkg::TX_STROBE || st == hsp_pkg::TX_HOLD);
    assign data_out = dq;
endmodule

// File: rtl/hsp_rx.sv
module hsp_rx #(
    parameter int DW = 8,
    parameter int GAP_CYC = 2,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          dav_s_n,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          rdy
);
    hsp_pkg::rx_state_e st;
    logic [CW-1:0]      cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st       <= hsp_pkg::RX_READY;
            cnt      <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            case (st)
                hsp_pkg::RX_READY: if (!dav_s_n) begin
                    st       <= hsp_pkg::RX_ACK;
                    rd_valid <= 1'b1;
                end
                hsp_pkg::RX_ACK: if (dav_s_n) begin
                    st  <= hsp_pkg::RX_GAP;
                    cnt <= CW'(GAP_CYC - 1);
                end
                hsp_pkg::RX_GAP: begin
                    if (cnt != '0) cnt <= cnt - CW'(1);
                    else st <= hsp_pkg::RX_READY;
                end
                default: st <= hsp_pkg::RX_READY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else if (en && st == hsp_pkg::RX_READY && !dav_s_n) rd_data <= data_in;
    end

    assign rdy = (st == hsp_pkg::RX_READY);
endmodule

// File: rtl/strobe_port.sv
module strobe_port #(
    parameter int DW = 8,
    parameter int SETUP_CYC = 2,
    parameter int DAV_MIN_CYC = 3,
    parameter int GAP_CYC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_out,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          busy,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    input  logic [DW-1:0] pin_data_in,
    output logic [DW-1:0] pin_data_out,
    output logic          pin_data_oe,
    input  logic          dav_n_in,
    output logic          dav_n_out,
    output logic          dav_oe,
    input  logic          rdy_in,
    output logic          rdy_out,
    output logic          rdy_oe
);
    localparam int CNT_MAX = hsp_pkg::max3(SETUP_CYC, DAV_MIN_CYC, GAP_CYC);
    localparam int CW      = hsp_pkg::cbits(CNT_MAX);

    hsp_pkg::hs_lines_t raw_lines, sync_lines;

    assign raw_lines.dav_n = dav_n_in;
    assign raw_lines.rdy   = rdy_in;

    hsp_sync #(
        .W      ($bits(hsp_pkg::hs_lines_t)),
        .STAGES (hsp_pkg::SYNC_STAGES),
        .RST_VAL(2'b11)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw_lines),
        .q  (sync_lines)
    );

    hsp_tx #(
        .DW(DW), .SETUP_CYC(SETUP_CYC), .DAV_MIN_CYC(DAV_MIN_CYC),
        .GAP_CYC(GAP_CYC), .CW(CW)
    ) u_tx (
        .clk     (clk),
        .rst     (rst),
        .en      (mode_out),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rdy_s   (sync_lines.rdy),
        .busy    (busy),
        .data_out(pin_data_out),
        .dav_n   (dav_n_out)
    );

    hsp_rx #(
        .DW(DW), .GAP_CYC(GAP_CYC), .CW(CW)
    ) u_rx (
        .clk     (clk),
        .rst     (rst),
        .en      (!mode_out),
        .dav_s_n (sync_lines.dav_n),
        .data_in (pin_data_in),
        .rd_data (rd_data),
        .rd_valid(rd_valid),
        .rdy     (rdy_out)
    );

    assign pin_data_oe = mode_out;
    assign dav_oe      = mode_out;
    assign rdy_oe      = !mode_out;
endmodule

// File: rtl/strobe_port_chk.sv
module strobe_port_chk #(
    parameter int DW = 8,
    parameter int SETUP_CYC = 2,
    parameter int DAV_MIN_CYC = 3,
    parameter int GAP_CYC = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          mode_out,
    input logic          wr_en,
    input logic          busy,
    input logic          rd_valid,
    input logic [DW-1:0] pin_data_out,
    input logic          dav_n_in,
    input logic          dav_n_out,
    input logic          rdy_in,
    input logic          rdy_out
);
    localparam int unsigned SAT = 32'h4000_0000;

    int unsigned   stab_cnt, since_rdy_fall, since_rdy_rise;
    logic [DW-1:0] data_q;
    logic          rdy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stab_cnt       <= 0;
            since_rdy_fall <= SAT;
            since_rdy_rise <= SAT;
            data_q         <= '0;
            rdy_q          <= 1'b1;
        end else begin
            data_q <= pin_data_out;
            rdy_q  <= rdy_in;
            if (pin_data_out != data_q) stab_cnt <= 0;
            else if (stab_cnt < SAT) stab_cnt <= stab_cnt + 1;
            if (rdy_q && !rdy_in) since_rdy_fall <= 0;
            else if (since_rdy_fall < SAT) since_rdy_fall <= since_rdy_fall + 1;
            if (!rdy_q && rdy_in) since_rdy_rise <= 0;
            else if (since_rdy_rise < SAT) since_rdy_rise <= since_rdy_rise + 1;
        end
    end

    // R3: stab_cnt lags one edge behind the change, hence the minus one
    a_r3_setup_window: assert property (@(posedge clk) disable iff (rst)
        mode_out && $fell(dav_n_out) |-> stab_cnt >= SETUP_CYC - 1);

    a_r4_strobe_hold: assert property (@(posedge clk) disable iff (rst)
        mode_out && $rose(dav_n_out) |-> since_rdy_fall >= DAV_MIN_CYC);

    a_r5_gap_respected: assert property (@(posedge clk) disable iff (rst)
        mode_out && $fell(dav_n_out) |-> since_rdy_rise >= GAP_CYC + SETUP_CYC);

    a_r6_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
        mode_out && busy && wr_en |=> $stable(pin_data_out));

    a_r7_valid_one_shot: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    a_r7_valid_with_ack: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $fell(rdy_out));

    a_r8_ready_after_strobe: assert property (@(posedge clk) disable iff (rst)
        !mode_out && !$past(mode_out) && $rose(rdy_out) |-> $past(dav_n_in) && $past(dav_n_in, 2));

    a_r9_idle_in_input_mode: assert property (@(posedge clk) disable iff (rst)
        !mode_out && !$past(mode_out) |-> !busy && dav_n_out);
endmodule

bind strobe_port strobe_port_chk #(
    .DW(DW), .SETUP_CYC(SETUP_CYC), .DAV_MIN_CYC(DAV_MIN_CYC), .GAP_CYC(GAP_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_out    (mode_out),
    .wr_en       (wr_en),
    .busy        (busy),
    .rd_valid    (rd_valid),
    .pin_data_out(pin_data_out),
    .dav_n_in    (dav_n_in),
    .dav_n_out   (dav_n_out),
    .rdy_in      (rdy_in),
    .rdy_out     (rdy_out)
);

// File: tb/tb_strobe_port.sv
module tb_strobe_port;
    localparam int CLK_PERIOD = 10;
    localparam int SU = 3;
    localparam int DM = 4;
    localparam int GP = 2;

    logic       clk = 1'b0, rst = 1'b1, mode_out = 1'b1, wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00, pin_data_in = 8'h00;
    logic       dav_n_in = 1'b1, rdy_in = 1'b1;
    logic       busy, rd_valid, pin_data_oe, dav_n_out, dav_oe, rdy_out, rdy_oe;
    logic [7:0] rd_data, pin_data_out;

    int cyc = 0, checks = 0, errors = 0, rx_lat = 1, t_rise = -1000, t_dav = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    strobe_port #(.DW(8), .SETUP_CYC(SU), .DAV_MIN_CYC(DM), .GAP_CYC(GP)) dut (
        .clk(clk), .rst(rst), .mode_out(mode_out), .wr_en(wr_en), .wr_data(wr_data),
        .busy(busy), .rd_data(rd_data), .rd_valid(rd_valid),
        .pin_data_in(pin_data_in), .pin_data_out(pin_data_out), .pin_data_oe(pin_data_oe),
        .dav_n_in(dav_n_in), .dav_n_out(dav_n_out), .dav_oe(dav_oe),
        .rdy_in(rdy_in), .rdy_out(rdy_out), .rdy_oe(rdy_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Far-end receiver model for output mode, with scoreboard pop
    initial begin : ext_receiver
        logic       dprev;
        logic [7:0] last, e;
        int         stab, t;
        dprev = 1'b1; last = 8'h00; stab = 0;
        forever begin
            @(negedge clk);
            if (pin_data_out != last) stab = 0; else stab++;
            last = pin_data_out;
            if (mode_out && dprev && !dav_n_out) begin
                chk(stab >= SU, "R3 data stable before strobe", stab, SU);
                chk(cyc - t_rise >= GP + SU, "R5 gap before next strobe", cyc - t_rise, GP + SU);
                if (txq.size() == 0) chk(1'b0, "R6 unexpected byte sent", int'(pin_data_out), 0);
                else begin
                    e = txq.pop_front();
                    chk(pin_data_out == e, "R3 byte on pins", int'(pin_data_out), int'(e));
                end
                repeat (rx_lat) @(negedge clk);
                chk(dav_n_out == 1'b0, "R4 strobe held until ready falls", int'(dav_n_out), 0);
                rdy_in = 1'b0; t = cyc;
                do @(negedge clk); while (dav_n_out == 1'b0);
                chk(cyc - t == DM + 3, "R4 strobe release delay", cyc - t, DM + 3);
                repeat (rx_lat) @(negedge clk);
                chk(busy == 1'b1, "R6 busy through handshake", int'(busy), 1);
                rdy_in = 1'b1; t = cyc; t_rise = cyc;
                do @(negedge clk); while (busy);
                chk(cyc - t == GP + 3, "R5 busy clear delay", cyc - t, GP + 3);
            end
            dprev = dav_n_out;
        end
    end

    // Read-side monitor for input mode, with scoreboard pop
    initial begin : rd_monitor
        logic       vprev;
        logic [7:0] e;
        vprev = 1'b0;
        forever begin
            @(negedge clk);
            if (rd_valid) begin
                chk(!vprev, "R7 valid lasts one cycle", int'(vprev), 0);
                if (rxq.size() == 0) chk(1'b0, "R9 unexpected received byte", int'(rd_data), 0);
                else begin
                    e = rxq.pop_front();
                    chk(rd_data == e, "R7 received byte", int'(rd_data), int'(e));
                    chk(cyc - t_dav == 3, "R7 latch latency", cyc - t_dav, 3);
                end
            end
            vprev = rd_valid;
        end
    end

    task automatic send_tx(input logic [7:0] b);
        while (busy) @(negedge clk);
        wr_en = 1'b1; wr_data = b; txq.push_back(b);
        @(negedge clk);
        wr_en = 1'b0;
        chk(busy == 1'b1, "R6 busy set after write", int'(busy), 1);
        chk(pin_data_out == b, "R3 byte driven after write", int'(pin_data_out), int'(b));
    endtask

    task automatic write_while_busy(input logic [7:0] b, input logic [7:0] keep);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
        chk(pin_data_out == keep, "R6 write while busy ignored", int'(pin_data_out), int'(keep));
        chk(busy == 1'b1, "R6 busy stays set", int'(busy), 1);
    endtask

    task automatic wait_tx_idle;
        while (busy || txq.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] b, input int width);
        int t;
        pin_data_in = b; dav_n_in = 1'b0; rxq.push_back(b); t_dav = cyc;
        do @(negedge clk); while (rdy_out);
        chk(cyc - t_dav == 3, "R7 ready drop latency", cyc - t_dav, 3);
        pin_data_in = ~b;
        repeat (width) begin
            @(negedge clk);
            chk(rdy_out == 1'b0, "R8 ready low while strobe low", int'(rdy_out), 0);
        end
        dav_n_in = 1'b1; t = cyc;
        do @(negedge clk); while (!rdy_out);
        chk(cyc - t == GP + 3, "R8 ready return delay", cyc - t, GP + 3);
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 50000);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        chk(rd_valid == 1'b0, "R1 valid in reset", int'(rd_valid), 0);
        chk(rd_data == 8'h00, "R1 read data in reset", int'(rd_data), 0);
        chk(dav_n_out == 1'b1, "R1 strobe idle in reset", int'(dav_n_out), 1);
        chk(rdy_out == 1'b1, "R1 ready idle in reset", int'(rdy_out), 1);
        chk(pin_data_oe && dav_oe && !rdy_oe, "R2 output-mode enables", int'({pin_data_oe, dav_oe, rdy_oe}), 6);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && dav_n_out == 1'b1, "R1 idle after reset", int'(busy), 0);

        rx_lat = 1;
        send_tx(8'hA5);
        write_while_busy(8'h11, 8'hA5);
        send_tx(8'h5A);
        send_tx(8'h00);
        send_tx(8'hFF);
        wait_tx_idle();
        rx_lat = 6;
        send_tx(8'h3C);
        send_tx(8'hC3);
        wait_tx_idle();

        mode_out = 1'b0;
        @(negedge clk);
        chk(!pin_data_oe && !dav_oe && rdy_oe, "R2 input-mode enables", int'({pin_data_oe, dav_oe, rdy_oe}), 1);
        wr_en = 1'b1; wr_data = 8'h99;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R9 write in input mode ignored", int'(busy), 0);
        chk(dav_n_out == 1'b1, "R9 no strobe in input mode", int'(dav_n_out), 1);

        send_rx(8'h81, 1);
        send_rx(8'h7E, 5);
        send_rx(8'h00, 2);
        send_rx(8'hFF, 3);
        repeat (2) @(negedge clk);
        chk(rxq.size() == 0, "R7 all bytes received", rxq.size(), 0);

        mode_out = 1'b1;
        @(negedge clk);
        dav_n_in = 1'b0;
        repeat (10) @(negedge clk);
        chk(rdy_out == 1'b1, "R9 ready unaffected in output mode", int'(rdy_out), 1);
        chk(rd_valid == 1'b0, "R9 no valid in output mode", int'(rd_valid), 0);
        dav_n_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(txq.size() == 0, "R3 all bytes sent", txq.size(), 0);
        finish_run();
    end
endmodule